// File: doc/BRIEF.md
# Cassette Record Tone Encoder

This block turns a stream of bytes into one recorded tape record. The record is a one-bit square wave that a recorder can store. It sends a run of low tone as a lead-in, then a short marker symbol, then the bytes, then one check byte. Every symbol is two half-cycles. The output level flips at the end of each half-cycle. The symbol type sets the length of its halves, and that length is what a reader measures. The absolute level of the output carries no meaning.

A host sets the lead-in length in half-cycles and pulses a start strobe. It then supplies bytes over a valid/ready handshake and flags the final byte. The encoder asks for the next byte only at the clock where the previous byte finishes. A source that holds its byte ready therefore leaves no gap. A source that is late stretches the current level until its byte arrives. All timing counts in whole ticks. A tick is one microsecond, taken from the system clock by a programmable divider.

Top module: `tape_rec_enc`

## Requirements
- R1: After a start, the record opens with `hdr_len` half-cycles of 650 ticks each. A `hdr_len` of 0 leaves out the lead-in entirely.
- R2: After the lead-in comes the marker symbol: one half-cycle of 200 ticks, then one of 250 ticks.
- R3: Each data bit is two equal half-cycles: 250 ticks for a 0 and 500 ticks for a 1. Bytes go out in the order they are accepted, each with its most significant bit (bit 7) first.
- R4: After the byte flagged by `din_last`, the encoder sends one check byte. The check byte is 0xFF XORed with every data byte of the record. It uses the same bit encoding and bit order as the data.
- R5: `tape_out` changes level exactly at the end of each half-cycle and at no other time. A record therefore makes as many level changes as it has half-cycles.
- R6: A tick is `CLKS_PER_TICK` clock cycles. A half-cycle of N ticks lasts exactly N × `CLKS_PER_TICK` clock cycles, measured from the previous level change. The first half-cycle is measured from the clock edge that accepts start.
- R7: `din_ready` is high only in two cases. The first is the clock in which the last half-cycle of the marker, or of a data byte that was not flagged last, ends. The second is while the encoder waits for a byte. A byte is taken on a clock edge where `din_valid` and `din_ready` are both high.
- R8: If no byte is valid when one is needed, the output holds its level and `din_ready` stays high. The half-cycle after the byte is finally accepted still has its full length.
- R9: Start is accepted only while idle, and `busy` rises on the accepting edge. A start pulse while `busy` is high is ignored.
- R10: `done` pulses high for exactly one clock on the edge that makes the record's final level change. `busy` falls on that same edge.
- R11: Reset gives `tape_out` = 0, `busy` = 0, `done` = 0 and `din_ready` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a record when idle |
| hdr_len | input | HDR_W | Lead-in length in half-cycles, sampled at start |
| din | input | 8 | Data byte |
| din_valid | input | 1 | Data byte present |
| din_ready | output | 1 | Encoder takes the byte on this edge if valid |
| din_last | input | 1 | Marks the final data byte of the record |
| busy | output | 1 | A record is in progress |
| done | output | 1 | One-cycle pulse at the end of the record |
| tape_out | output | 1 | Square-wave output to the recorder |

## Verification
The assertions expect `start` to be a clean strobe and every byte to be flagged by `din_last` before the source stops offering data. The minimum-half-cycle check also assumes that no reset arrives in the middle of a record. The bench offers each byte at a falling edge and holds it until a handshake completes. Every record it sends ends with a flagged byte. The bench stalls the source only at a point where `din_ready` is already high, so the stretch it causes has a known lower bound. It repeats a start strobe during a record only to show that the strobe is ignored.

// File: rtl/tape_enc_pkg.sv
package tape_enc_pkg;

    localparam int unsigned DATA_W       = 8;
    localparam int unsigned LEN_W        = 10;
    localparam int unsigned LEAD_HALF_US = 650;
    localparam int unsigned MARK_A_US    = 200;
    localparam int unsigned MARK_B_US    = 250;
    localparam int unsigned ZERO_HALF_US = 250;
    localparam int unsigned ONE_HALF_US  = 500;
    localparam int unsigned MIN_HALF_US  = 200;

    typedef enum logic [2:0] {
        ENC_IDLE,
        ENC_LEAD,
        ENC_MARK,
        ENC_DATA,
        ENC_WAIT
    } enc_state_e;

    typedef enum logic [1:0] {
        SYM_LEAD,
        SYM_MARK,
        SYM_ZERO,
        SYM_ONE
    } sym_e;

    typedef struct packed {
        sym_e sym;
        logic second;
    } half_t;

    typedef struct packed {
        logic [DATA_W-1:0] bits;
        logic [2:0]        idx;
        logic              last;
        logic              is_check;
    } slot_t;

    function automatic logic [LEN_W-1:0] half_ticks(input sym_e s, input logic second);
        logic [LEN_W-1:0] n;
        case (s)
            SYM_LEAD: n = LEN_W'(LEAD_HALF_US);
            SYM_MARK: n = second ? LEN_W'(MARK_B_US) : LEN_W'(MARK_A_US);
            SYM_ZERO: n = LEN_W'(ZERO_HALF_US);
            default:  n = LEN_W'(ONE_HALF_US);
        endcase
        return n;
    endfunction

    function automatic sym_e bit_sym(input logic b);
        return b ? SYM_ONE : SYM_ZERO;
    endfunction

endpackage

// File: rtl/tape_tick_gen.sv
module tape_tick_gen #(
    parameter int unsigned CLKS_PER_TICK = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    localparam int unsigned CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [CW-1:0] TOP = CW'(CLKS_PER_TICK - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (cnt_q == TOP) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == TOP);
endmodule

// File: rtl/tape_half_timer.sv
module tape_half_timer
    import tape_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic             tick,
    input  logic [LEN_W-1:0] len,
    output logic             expire
);
    logic [LEN_W-1:0] cnt_q;

    assign expire = run && tick && (cnt_q == len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= expire ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tape_rec_enc.sv
module tape_rec_enc
    import tape_enc_pkg::*;
#(
    parameter int unsigned CLKS_PER_TICK = 125,
    parameter int unsigned HDR_W         = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [HDR_W-1:0]  hdr_len,
    input  logic [DATA_W-1:0] din,
    input  logic              din_valid,
    output logic              din_ready,
    input  logic              din_last,
    output logic              busy,
    output logic              done,
    output logic              tape_out
);
    localparam logic [DATA_W-1:0] CHECK_SEED = {DATA_W{1'b1}};
    localparam logic [2:0]        TOP_BIT    = 3'(DATA_W - 1);

    enc_state_e        state_q, state_d;
    half_t             half_q, half_d;
    slot_t             slot_q, slot_d;
    logic [HDR_W-1:0]  lead_left_q, lead_left_d;
    logic [DATA_W-1:0] check_q, check_d;
    logic              out_q, done_q, done_d;

    logic             tick, half_end, restart, running, at_boundary, accept;
    logic [LEN_W-1:0] cur_len;

    assign running = (state_q == ENC_LEAD) || (state_q == ENC_MARK) || (state_q == ENC_DATA);
    assign cur_len = half_ticks(half_q.sym, half_q.second);

    tape_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .clear (restart),
        .tick  (tick)
    );

    tape_half_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .run     (running),
        .tick    (tick),
        .len     (cur_len),
        .expire  (half_end)
    );

    // A byte is wanted where the marker or a non-final data byte completes.
    assign at_boundary = half_end && half_q.second &&
                         ((state_q == ENC_MARK) ||
                          (state_q == ENC_DATA && slot_q.idx == '0 &&
                           !slot_q.is_check && !slot_q.last));
    assign din_ready = at_boundary || (state_q == ENC_WAIT);
    assign accept    = din_ready && din_valid;

    always_comb begin
        state_d     = state_q;
        half_d      = half_q;
        slot_d      = slot_q;
        lead_left_d = lead_left_q;
        check_d     = check_q;
        done_d      = 1'b0;
        restart     = 1'b0;

        case (state_q)
            ENC_IDLE: begin
                if (start) begin
                    restart     = 1'b1;
                    check_d     = CHECK_SEED;
                    slot_d      = '0;
                    lead_left_d = hdr_len;
                    if (hdr_len == '0) begin
                        state_d = ENC_MARK;
                        half_d  = '{sym: SYM_MARK, second: 1'b0};
                    end else begin
                        state_d = ENC_LEAD;
                        half_d  = '{sym: SYM_LEAD, second: 1'b0};
                    end
                end
            end
            ENC_LEAD: begin
                if (half_end) begin
                    lead_left_d = lead_left_q - 1'b1;
                    if (lead_left_q == HDR_W'(1)) begin
                        state_d = ENC_MARK;
                        half_d  = '{sym: SYM_MARK, second: 1'b0};
                    end
                end
            end
            ENC_MARK: begin
                if (half_end && !half_q.second) begin
                    half_d.second = 1'b1;
                end
            end
            ENC_DATA: begin
                if (half_end) begin
                    if (!half_q.second) begin
                        half_d.second = 1'b1;
                    end else if (slot_q.idx != '0) begin
                        slot_d.bits = {slot_q.bits[DATA_W-2:0], 1'b0};
                        slot_d.idx  = slot_q.idx - 1'b1;
                        half_d      = '{sym: bit_sym(slot_q.bits[DATA_W-2]), second: 1'b0};
                    end else if (slot_q.is_check) begin
                        state_d = ENC_IDLE;
                        done_d  = 1'b1;
                    end else if (slot_q.last) begin
                        slot_d = '{bits: check_q, idx: TOP_BIT, last: 1'b1, is_check: 1'b1};
                        half_d = '{sym: bit_sym(check_q[DATA_W-1]), second: 1'b0};
                    end
                end
            end
            ENC_WAIT: begin
                if (accept) begin
                    restart = 1'b1;
                end
            end
            default: state_d = ENC_IDLE;
        endcase

        if (at_boundary && !accept) begin
            state_d = ENC_WAIT;
        end
        if (accept) begin
            state_d = ENC_DATA;
            slot_d  = '{bits: din, idx: TOP_BIT, last: din_last, is_check: 1'b0};
            check_d = check_q ^ din;
            half_d  = '{sym: bit_sym(din[DATA_W-1]), second: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ENC_IDLE;
            half_q      <= '{sym: SYM_LEAD, second: 1'b0};
            slot_q      <= '0;
            lead_left_q <= '0;
            check_q     <= CHECK_SEED;
            out_q       <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            state_q     <= state_d;
            half_q      <= half_d;
            slot_q      <= slot_d;
            lead_left_q <= lead_left_d;
            check_q     <= check_d;
            out_q       <= out_q ^ half_end;
            done_q      <= done_d;
        end
    end

    assign busy     = (state_q != ENC_IDLE);
    assign done     = done_q;
    assign tape_out = out_q;
endmodule

// File: rtl/tape_rec_enc_chk.sv
module tape_rec_enc_chk
    import tape_enc_pkg::*;
#(
    parameter int unsigned CLKS_PER_TICK = 125
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic din_ready,
    input logic busy,
    input logic done,
    input logic tape_out
);
    localparam int unsigned MIN_CYC = MIN_HALF_US * CLKS_PER_TICK;

    logic        prev_out;
    logic [31:0] since_q;
    logic        flipped;

    assign flipped = (tape_out != prev_out);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_out <= 1'b0;
            since_q  <= '0;
        end else begin
            prev_out <= tape_out;
            if (flipped || (start && !busy)) begin
                since_q <= '0;
            end else if (since_q != 32'hFFFF_FFFF) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    // R5
    out_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tape_out) |-> $past(busy));

    // R6
    min_half_chk: assert property (@(posedge clk) disable iff (rst)
        flipped |-> (since_q >= MIN_CYC - 1));

    // R7
    ready_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        din_ready |-> busy);

    // R9
    busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
endmodule

bind tape_rec_enc tape_rec_enc_chk #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .din_ready (din_ready),
    .busy      (busy),
    .done      (done),
    .tape_out  (tape_out)
);

// File: tb/tape_rec_enc_bench.sv
module tape_rec_enc_bench;
    import tape_enc_pkg::*;

    localparam int unsigned P = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [15:0] hdr_len = '0;
    logic [7:0] din = '0;
    logic       din_valid = 1'b0;
    logic       din_last = 1'b0;
    logic       din_ready, busy, done, tape_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int tog_t [0:255];
    int exp_l [0:255];
    int n_tog, busy_t, done_t, done_cnt;
    logic prev_out = 1'b0, prev_busy = 1'b0;
    logic [7:0] tx [0:7];

    tape_rec_enc #(.CLKS_PER_TICK(P), .HDR_W(16)) u_tape_rec_enc (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .hdr_len   (hdr_len),
        .din       (din),
        .din_valid (din_valid),
        .din_ready (din_ready),
        .din_last  (din_last),
        .busy      (busy),
        .done      (done),
        .tape_out  (tape_out)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (tape_out !== prev_out) begin
                if (n_tog < 256) tog_t[n_tog] = cyc;
                n_tog = n_tog + 1;
            end
            if (busy && !prev_busy) busy_t = cyc;
            if (done) begin
                done_cnt = done_cnt + 1;
                done_t   = cyc;
            end
        end
        prev_out  = tape_out;
        prev_busy = busy;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bytes(input int n, input int stall_at, input int stall_cyc);
        for (int i = 0; i < n; i++) begin
            if (i == stall_at) begin
                din_valid = 1'b0;
                while (!din_ready) @(negedge clk);
                repeat (stall_cyc) @(negedge clk);
            end
            din       = tx[i];
            din_last  = (i == n - 1);
            din_valid = 1'b1;
            while (!din_ready) @(negedge clk);
            @(negedge clk);
        end
        din_valid = 1'b0;
        din_last  = 1'b0;
    endtask

    task automatic pulse_start(input int h);
        start   = 1'b1;
        hdr_len = 16'(h);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_record(input int hlen, input int n, input int stall_at,
                              input int stall_cyc, input int restrike);
        int idx, stall_idx, t_start, iv;
        logic [7:0] chk_byte, b;
        idx = 0;
        stall_idx = -1;
        for (int h = 0; h < hlen; h++) begin exp_l[idx] = 650; idx++; end
        exp_l[idx] = 200; idx++;
        exp_l[idx] = 250; idx++;
        chk_byte = 8'hFF;
        for (int k = 0; k <= n; k++) begin
            if (k < n) begin
                b = tx[k];
                chk_byte = chk_byte ^ tx[k];
            end else begin
                b = chk_byte;
            end
            if (k == stall_at) stall_idx = idx;
            for (int j = 7; j >= 0; j--) begin
                exp_l[idx] = b[j] ? 500 : 250; idx++;
                exp_l[idx] = b[j] ? 500 : 250; idx++;
            end
        end

        n_tog = 0; done_cnt = 0; busy_t = -1; done_t = -1;
        @(negedge clk);
        t_start = cyc;
        fork
            begin
                pulse_start(hlen);
                if (restrike > 0) begin
                    repeat (restrike) @(negedge clk);
                    pulse_start(7);
                end
            end
            begin
                send_bytes(n, stall_at, stall_cyc);
            end
        join
        while (done_cnt == 0) @(negedge clk);
        repeat (4) @(negedge clk);

        // R9: busy rises on the edge that accepts start
        chk(busy_t == t_start + 1, "R9 busy rise cycle", busy_t, t_start + 1);
        // R5: one level change per half-cycle
        chk(n_tog == idx, "R5 level change count", n_tog, idx);
        for (int k = 0; k < idx && k < n_tog; k++) begin
            iv = tog_t[k] - ((k == 0) ? busy_t : tog_t[k-1]);
            if (k == stall_idx) begin
                // R8: stretched by the stall, next halves unaffected
                chk(iv >= exp_l[k] * P + stall_cyc, "R8 stalled half length", iv, exp_l[k] * P + stall_cyc);
            end else if (k < hlen) begin
                chk(iv == exp_l[k] * P, "R1 R6 lead half length", iv, exp_l[k] * P);
            end else if (k < hlen + 2) begin
                chk(iv == exp_l[k] * P, "R2 marker half length", iv, exp_l[k] * P);
            end else if (k >= idx - 16) begin
                chk(iv == exp_l[k] * P, "R4 check byte half length", iv, exp_l[k] * P);
            end else begin
                chk(iv == exp_l[k] * P, "R3 R7 data half length", iv, exp_l[k] * P);
            end
        end
        // R10
        chk(done_cnt == 1, "R10 done pulse count", done_cnt, 1);
        chk(n_tog > 0 && done_t == tog_t[n_tog-1], "R10 done at final change", done_t,
            (n_tog > 0) ? tog_t[n_tog-1] : -1);
        chk(busy == 1'b0, "R10 busy low after record", int'(busy), 0);
        // R7
        chk(din_ready == 1'b0, "R7 ready low when idle", int'(din_ready), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11
        chk(tape_out == 1'b0, "R11 reset tape_out", int'(tape_out), 0);
        chk(busy == 1'b0, "R11 reset busy", int'(busy), 0);
        chk(done == 1'b0, "R11 reset done", int'(done), 0);
        chk(din_ready == 1'b0, "R11 reset ready", int'(din_ready), 0);

        // Record with lead-in and three bytes, source always ready
        tx[0] = 8'hB0; tx[1] = 8'h5A; tx[2] = 8'h01;
        run_record(3, 3, -1, 0, 0);

        // R1: no lead-in, single zero byte, check byte 0xFF
        tx[0] = 8'h00;
        run_record(0, 1, -1, 0, 0);

        // R8 stall before third byte, R9 second start ignored
        tx[0] = 8'hFF; tx[1] = 8'h00; tx[2] = 8'hC3; tx[3] = 8'h3C;
        run_record(2, 4, 2, 37, 3000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule